// File: doc/BRIEF.md
# GF(2) Bit Matrix Multiplier

This block multiplies two square matrices of single bits over GF(2), giving C = A x B mod 2. Each product element is the parity of the bitwise AND between one row of A and one column of B, so the multiply is an AND and the accumulate is an XOR. For the default size of 8, each matrix is packed into one 64-bit word, so the block takes two ordinary register operands and returns one.

The datapath is fully combinational and is followed by a single output register. An operand pair presented with `in_valid` high is captured at the next rising edge, and the product appears with `out_valid` one cycle later. When `in_valid` is low the output register keeps its last product.

Top module: `gf2_bmm`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `mat_c` is all zeros.
- R2: `out_valid` after a rising edge equals the `in_valid` sampled at that edge, so the latency is exactly one cycle.
- R3: For a captured pair, element (i,j) of `mat_c` is the XOR over k of a(i,k) AND b(k,j).
- R4: Element (i,j) of any matrix word sits at bit N*i + j. Row i fills bits [N*i+N-1 : N*i], and column j is bit j within that row.
- R5: If B is the identity (bits N*i + i set, all others clear), the product equals A.
- R6: If A is the identity, the product equals B.
- R7: If either operand is all zeros, the product is all zeros.
- R8: On an edge where `in_valid` is low, `mat_a` and `mat_b` are ignored and `mat_c` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| mat_a | input | N*N | Left operand, packed by rows |
| mat_b | input | N*N | Right operand, packed by rows |
| out_valid | output | 1 | `mat_c` holds a new product |
| mat_c | output | N*N | Packed product |

## Verification
Any fault in the product array, such as a wrong transpose wire or a missing AND term, changes specific bits of `mat_c` one cycle after the operands are captured. A single-bit probe of A against a single-bit probe of B therefore shows exactly which row and column are wrong. A faulty enable on the output register shows up in the first cycle with `in_valid` low: either `mat_c` changes when it should hold, or it fails to load when it should. A wrong valid pipeline shows up as `out_valid` one cycle out of step with the driven strobe.

// File: rtl/gf2_bmm_pkg.sv
package gf2_bmm_pkg;
  // Largest matrix side the shared helper supports.
  parameter int unsigned BMM_MAX_N = 16;

  // Inner product over GF(2): AND terms, XOR reduction.
  function automatic logic gf2_dot(input logic [BMM_MAX_N-1:0] row,
                                   input logic [BMM_MAX_N-1:0] col);
    return ^(row & col);
  endfunction
endpackage

// File: rtl/gf2_bmm.sv
module bmm_transpose #(
  parameter int unsigned N = 8,
  localparam int unsigned W = N * N
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  // dst row j, position k  <=  src row k, position j
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign dst[c*N + r] = src[r*N + c];
    end
  end
endmodule

module bmm_dot_array #(
  parameter int unsigned N = 8,
  localparam int unsigned W = N * N
) (
  input  logic [W-1:0] rows_a,
  input  logic [W-1:0] cols_b,
  output logic [W-1:0] prod
);
  import gf2_bmm_pkg::*;
  for (genvar i = 0; i < N; i++) begin : g_i
    logic [BMM_MAX_N-1:0] row_w;
    assign row_w = BMM_MAX_N'(rows_a[i*N +: N]);
    for (genvar j = 0; j < N; j++) begin : g_j
      logic [BMM_MAX_N-1:0] col_w;
      assign col_w = BMM_MAX_N'(cols_b[j*N +: N]);
      assign prod[i*N + j] = gf2_dot(row_w, col_w);
    end
  end
endmodule

module bmm_out_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         v_q,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      q   <= '0;
    end else begin
      v_q <= load;
      if (load) q <= d;
    end
  end
endmodule

module gf2_bmm #(
  parameter int unsigned N = 8,
  localparam int unsigned W = N * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] mat_a,
  input  logic [W-1:0] mat_b,
  output logic         out_valid,
  output logic [W-1:0] mat_c
);
  // Columns of B laid out as rows, and the combinational product.
  logic [W-1:0] b_cols;
  logic [W-1:0] prod_comb;

  bmm_transpose #(.N(N)) u_tr (
    .src (mat_b),
    .dst (b_cols)
  );

  bmm_dot_array #(.N(N)) u_dot (
    .rows_a (mat_a),
    .cols_b (b_cols),
    .prod   (prod_comb)
  );

  bmm_out_reg #(.W(W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (prod_comb),
    .v_q   (out_valid),
    .q     (mat_c)
  );
endmodule

// File: rtl/gf2_bmm_chk.sv
module gf2_bmm_chk #(
  parameter int unsigned N = 8,
  localparam int unsigned W = N * N
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] mat_a,
  input logic [W-1:0] mat_b,
  input logic         out_valid,
  input logic [W-1:0] mat_c,
  input logic [W-1:0] prod_comb
);
  function automatic logic [W-1:0] ident_word();
    logic [W-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i*N + i] = 1'b1;
    return r;
  endfunction
  localparam logic [W-1:0] IDENT = ident_word();

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && mat_c == '0));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> mat_c == $past(prod_comb));

  // R5
  ident_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mat_b == IDENT) |=> mat_c == $past(mat_a));

  // R6
  ident_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mat_a == IDENT) |=> mat_c == $past(mat_b));

  // R7
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mat_a == '0 || mat_b == '0)) |=> mat_c == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mat_c));
endmodule

bind gf2_bmm gf2_bmm_chk #(.N(N)) u_chk (.*);

// File: tb/gf2_bmm_bench.sv
module gf2_bmm_bench;
  localparam int N = 8;
  localparam int W = N * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] mat_a = '0;
  logic [W-1:0] mat_b = '0;
  logic         out_valid;
  logic [W-1:0] mat_c;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string phase = "R1";

  // Reference state, kept behaviourally.
  logic         exp_v = 1'b0;
  logic [W-1:0] exp_c = '0;

  always #10 clk = ~clk;  // 50 MHz

  gf2_bmm #(.N(N)) u_gf2_bmm (.*);

  // Triple-loop reference: c(i,j) = XOR_k a(i,k) & b(k,j), element (i,j) at bit N*i+j.
  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int acc = 0;
        for (int k = 0; k < N; k++)
          acc = acc ^ int'(a[i*N + k] & b[k*N + j]);
        r[i*N + j] = acc[0];
      end
    return r;
  endfunction

  function automatic logic [W-1:0] ident();
    logic [W-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i*N + i] = 1'b1;
    return r;
  endfunction

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0;
      exp_c <= '0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) exp_c <= ref_mul(mat_a, mat_b);
    end
  end

  task automatic compare();
    compared++;
    if (out_valid !== exp_v) begin
      mismatched++;
      $display("FAIL R2 out_valid: actual %0b expected %0b", out_valid, exp_v);
    end
    compared++;
    if (mat_c !== exp_c) begin
      mismatched++;
      $display("FAIL %s mat_c: actual %h expected %h", phase, mat_c, exp_c);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    compare();
    in_valid = v;
    mat_a = a;
    mat_b = b;
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state, with stimulus driven during reset
    phase = "R1";
    step(1'b1, rnd64(), rnd64());
    step(1'b1, rnd64(), rnd64());
    step(1'b0, '0, '0);
    rst_n = 1'b1;

    // R5: B is identity
    phase = "R5";
    for (int t = 0; t < 8; t++) step(1'b1, rnd64(), ident());
    // R6: A is identity
    phase = "R6";
    for (int t = 0; t < 8; t++) step(1'b1, ident(), rnd64());
    // R7: zero operand on either side
    phase = "R7";
    for (int t = 0; t < 4; t++) step(1'b1, '0, rnd64());
    for (int t = 0; t < 4; t++) step(1'b1, rnd64(), '0);
    // R4: single-bit probes place a(i,k)&b(k,j) at bit N*i+j
    phase = "R4";
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int k = (i + 3 * j) % N;
        step(1'b1, W'(1) << (i*N + k), W'(1) << (k*N + j));
      end
    // R3: random pairs, back to back
    phase = "R3";
    for (int t = 0; t < 300; t++) step(1'b1, rnd64(), rnd64());
    // R8 with R2: random strobe, inputs keep changing while idle
    phase = "R8";
    for (int t = 0; t < 300; t++) step(($urandom() % 3) == 0, rnd64(), rnd64());
    step(1'b0, rnd64(), rnd64());
    step(1'b0, rnd64(), rnd64());

    // R1: reset in mid-run clears the output
    phase = "R1";
    step(1'b1, rnd64(), rnd64());
    step(1'b0, '0, '0);
    rst_n = 1'b0;
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule